// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block turns pin activity into interrupt request lines. Eight external pins each have their own request output. Every external pin has a two-bit sense setting that chooses one of four modes: a held low level, any transition, falling transitions only, or rising transitions only. Transitions set a per-pin pending flag. A low level drives the request directly and does not use the flag. Twenty-four further inputs form three banks of eight. Each bank drives one request whenever an enabled pin in that bank changes state in either direction.

The block does not care which way a pin is driven. If firmware drives a pin as an output, the pin still reaches these inputs, so toggling it raises an interrupt under software control. All pins pass through a two-flop synchroniser before any detection. Software configures the block through a narrow write-only port. Pending flags are cleared by writing ones to them, or by the acknowledge inputs when the interrupt controller takes the request. Flags can set while their request is masked, and such a flag is still pending when the mask bit is set later. After changing a sense setting, software should write the pin's clear bit to drop any flag the change left behind.

Top module: `irq_pin_unit`

## Requirements
- R1: After reset, every request output is low, all enable and bank masks are zero, and every sense setting is 00, which is low level.
- R2: With sense 00, `ext_req[i]` is high for exactly as long as the synchronised pin is low, provided its mask bit and `global_en` are set. Level mode never sets the pin's flag.
- R3: With sense 01, both a rising and a falling transition of the synchronised pin set the pin's flag.
- R4: With sense 10, only a falling transition sets the flag. A rising transition leaves it unchanged.
- R5: With sense 11, only a rising transition sets the flag. A falling transition leaves it unchanged.
- R6: In the three transition modes, `ext_req[i]` equals flag AND mask bit AND `global_en`. A flag sets even while its mask bit is clear. Clearing `global_en` forces every request output low.
- R7: Writing to the flag-clear address clears each flag whose data bit is one and leaves the others unchanged. If a transition is detected in the same cycle as the clear, the flag stays set.
- R8: A one-cycle pulse on `ext_ack[i]` clears flag i, unless a new transition is detected in that same cycle.
- R9: Bank g (pins 8g to 8g+7) sets its flag when any pin whose bank-mask bit is set changes level in either direction. Changes on masked pins have no effect. `pc_req[g]` equals that flag AND `global_en`.
- R10: A bank flag is cleared by writing a one to bit g at the bank-clear address, or by a pulse on `pc_ack[g]`.
- R11: A change on an input pin becomes visible in a level request two clock edges later, and in a flag-driven request three clock edges later.
- R12: Register write addresses (8-bit data):
  - 0: enable mask, where bit i enables external pin i.
  - 1: sense settings for pins 0 to 3. Pin i uses bits 2i+1:2i.
  - 2: sense settings for pins 4 to 7. Pin i uses bits 2(i-4)+1:2(i-4).
  - 3: external flag clear, write one to clear.
  - 4, 5, 6: masks for banks 0, 1 and 2.
  - 7: bank flag clear, bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| global_en | input | 1 | Global interrupt enable |
| ext_pin | input | 8 | External interrupt pin levels (asynchronous) |
| pc_pin | input | 24 | Pin-change input levels (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| ext_ack | input | 8 | Per-pin acknowledge; clears the edge flag |
| pc_ack | input | 3 | Per-bank acknowledge; clears the bank flag |
| ext_req | output | 8 | External interrupt requests |
| pc_req | output | 3 | Pin-change bank requests |

## Verification
A stale or wrongly set flag shows up as a request that stays high after a clear or an acknowledge, or as a request that appears as soon as a mask bit is set. In both cases it is visible on the next sampled cycle. A wrong previous-value register, or a sense decode that is off by one, shows up three edges after a pin transition: the request either fails to rise or rises for the wrong polarity. A synchroniser with the wrong number of stages moves the request edge by one cycle, so the latency probes at two and three edges expose it.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int ADDR_W          = 3;
  localparam int ADDR_EXT_MASK   = 0;
  localparam int ADDR_SENSE_BASE = 1;
  localparam int ADDR_EXT_CLR    = 3;
  localparam int ADDR_PC_MASK    = 4;
  localparam int ADDR_PC_CLR     = 7;

  // Transition qualifier: does the move prev -> cur count under this sense?
  function automatic logic edge_hit(sense_e s, logic cur, logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (s)
      SENSE_ANY:  edge_hit = rise | fall;
      SENSE_FALL: edge_hit = fall;
      SENSE_RISE: edge_hit = rise;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  // Level qualifier: active-low level only in SENSE_LOW.
  function automatic logic level_hit(sense_e s, logic cur);
    level_hit = (s == SENSE_LOW) && !cur;
  endfunction

  // Any enabled bit differs from its previous value.
  function automatic logic bank_toggle(logic [7:0] cur, logic [7:0] prev, logic [7:0] msk);
    bank_toggle = |((cur ^ prev) & msk);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      q1 <= din;
      q2 <= q1;
    end
  end

  assign dout = q2;

  assert_sync_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q2 == $past(q1));

endmodule

// File: rtl/irq_ext_channel.sv
module irq_ext_channel
  import irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  sense_e sense,
  input  logic   mask,
  input  logic   gie,
  input  logic   clr,
  input  logic   ack,
  output logic   req
);
  logic prev_q;
  logic flag_q;
  logic edge_evt;
  logic level_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  assign edge_evt  = edge_hit(sense, pin, prev_q);
  assign level_evt = level_hit(sense, pin);

  // Set takes priority so an edge landing with a clear is not lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (edge_evt)   flag_q <= 1'b1;
    else if (clr || ack) flag_q <= 1'b0;
  end

  assign req = gie & mask & ((sense == SENSE_LOW) ? level_evt : flag_q);

  assert_level_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LOW) |=> !$rose(flag_q));

  assert_edge_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> flag_q);

  assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(pin) != $past(prev_q)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_evt) |=> !flag_q);

  assert_clr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_evt) |=> !flag_q);

endmodule

// File: rtl/irq_pc_bank.sv
module irq_pc_bank
  import irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] mask,
  input  logic         gie,
  input  logic         clr,
  input  logic         ack,
  output logic         req
);
  logic [W-1:0] prev_q;
  logic         flag_q;
  logic         hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins;
  end

  assign hit = |((pins ^ prev_q) & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (clr || ack) flag_q <= 1'b0;
  end

  assign req = flag_q & gie;

  assert_bank_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_bank_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (($past(pins) ^ $past(prev_q)) != '0));

  assert_bank_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr || ack) && !hit) |=> !flag_q);

endmodule

// File: rtl/irq_pin_unit.sv
module irq_pin_unit
  import irq_pkg::*;
#(
  parameter int N_EXT     = 8,
  parameter int PC_GROUPS = 3,
  parameter int GROUP_W   = 8,
  parameter int DATA_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           global_en,
  input  logic [N_EXT-1:0]               ext_pin,
  input  logic [PC_GROUPS*GROUP_W-1:0]   pc_pin,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [N_EXT-1:0]               ext_ack,
  input  logic [PC_GROUPS-1:0]           pc_ack,
  output logic [N_EXT-1:0]               ext_req,
  output logic [PC_GROUPS-1:0]           pc_req
);
  localparam int PC_PINS      = PC_GROUPS * GROUP_W;
  localparam int PINS_PER_REG = DATA_W / 2;

  logic [N_EXT-1:0]   ext_sync;
  logic [PC_PINS-1:0] pc_sync;
  logic [N_EXT-1:0]   ext_mask_q;
  sense_e             sense_q [N_EXT];
  logic [GROUP_W-1:0] pc_mask_q [PC_GROUPS];
  logic [N_EXT-1:0]   ext_clr;
  logic [PC_GROUPS-1:0] pc_clr;

  irq_sync #(.W(N_EXT)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .din(ext_pin), .dout(ext_sync));

  irq_sync #(.W(PC_PINS)) u_sync_pc (
    .clk(clk), .rst_n(rst_n), .din(pc_pin), .dout(pc_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_mask_q <= '0;
      for (int i = 0; i < N_EXT; i++) sense_q[i] <= SENSE_LOW;
      for (int g = 0; g < PC_GROUPS; g++) pc_mask_q[g] <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_EXT_MASK))
        ext_mask_q <= wr_data[N_EXT-1:0];
      for (int i = 0; i < N_EXT; i++)
        if (wr_addr == ADDR_W'(ADDR_SENSE_BASE + i / PINS_PER_REG))
          sense_q[i] <= sense_e'(wr_data[2*(i % PINS_PER_REG) +: 2]);
      for (int g = 0; g < PC_GROUPS; g++)
        if (wr_addr == ADDR_W'(ADDR_PC_MASK + g))
          pc_mask_q[g] <= wr_data[GROUP_W-1:0];
    end
  end

  assign ext_clr = (wr_en && wr_addr == ADDR_W'(ADDR_EXT_CLR)) ? wr_data[N_EXT-1:0] : '0;
  assign pc_clr  = (wr_en && wr_addr == ADDR_W'(ADDR_PC_CLR))  ? wr_data[PC_GROUPS-1:0] : '0;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    irq_ext_channel u_ch (
      .clk(clk), .rst_n(rst_n), .pin(ext_sync[i]), .sense(sense_q[i]),
      .mask(ext_mask_q[i]), .gie(global_en), .clr(ext_clr[i]),
      .ack(ext_ack[i]), .req(ext_req[i]));
  end

  for (genvar g = 0; g < PC_GROUPS; g++) begin : g_pc
    irq_pc_bank #(.W(GROUP_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .pins(pc_sync[g*GROUP_W +: GROUP_W]),
      .mask(pc_mask_q[g]), .gie(global_en), .clr(pc_clr[g]),
      .ack(pc_ack[g]), .req(pc_req[g]));
  end

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !global_en |-> (ext_req == '0 && pc_req == '0));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_req & ~ext_mask_q) == '0));

endmodule

// File: tb/tb_irq_pin_unit.sv
module tb_irq_pin_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        global_en = 1'b0;
  logic [7:0]  ext_pin = '0;
  logic [23:0] pc_pin = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  ext_ack = '0;
  logic [2:0]  pc_ack = '0;
  logic [7:0]  ext_req;
  logic [2:0]  pc_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] sense_lo = 8'h00;

  always #10 clk = ~clk;

  irq_pin_unit dut (
    .clk(clk), .rst_n(rst_n), .global_en(global_en), .ext_pin(ext_pin),
    .pc_pin(pc_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_ack(ext_ack), .pc_ack(pc_ack), .ext_req(ext_req), .pc_req(pc_req));

  // {sense[1:0], level before, level after, expected request}
  localparam logic [4:0] VEC [8] = '{
    5'b01_0_1_1, 5'b01_1_0_1, 5'b10_0_1_0, 5'b10_1_0_1,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b00_1_0_1, 5'b00_0_1_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Called just after a negedge; write lands on the following posedge.
  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'b00: tag_of = "R2 level";
      2'b01: tag_of = "R3 any edge";
      2'b10: tag_of = "R4 falling";
      default: tag_of = "R5 rising";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ext_req after reset", ext_req, 8'h00);
    chk("R1 pc_req after reset", pc_req, 3'b000);

    // R1: reset sense is low level, so enabling pin 0 while it is low requests.
    global_en = 1'b1;
    write_reg(3'd0, 8'h01);            // R12 enable mask address
    chk("R1 reset sense is level", ext_req, 8'h01);

    for (int v = 0; v < 8; v++) begin
      sense_lo[1:0] = VEC[v][4:3];
      write_reg(3'd1, sense_lo);
      ext_pin[0] = VEC[v][2];
      waitn(4);
      write_reg(3'd3, 8'h01);
      ext_pin[0] = VEC[v][1];
      waitn(4);
      chk(tag_of(VEC[v][4:3]), ext_req[0], VEC[v][0]);
    end

    // R6: flag sets while masked, then shows once the mask is set.
    sense_lo[3:2] = 2'b11;
    write_reg(3'd1, sense_lo);
    write_reg(3'd3, 8'hFF);
    ext_pin[1] = 1'b1;
    waitn(4);
    chk("R6 masked pin quiet", ext_req[1], 1'b0);
    write_reg(3'd0, 8'h02);
    chk("R6 pending after unmask R12", ext_req, 8'h02);
    global_en = 1'b0;
    @(negedge clk);
    chk("R6 global disable", ext_req, 8'h00);
    global_en = 1'b1;
    @(negedge clk);

    // R7: clear only where ones are written.
    write_reg(3'd3, 8'h00);
    chk("R7 zero write keeps flag", ext_req[1], 1'b1);
    write_reg(3'd3, 8'h02);
    chk("R7 one write clears flag", ext_req, 8'h00);
    ext_pin[1] = 1'b0;
    waitn(4);
    chk("R5 falling ignored", ext_req[1], 1'b0);
    ext_pin[1] = 1'b1;
    waitn(2);
    write_reg(3'd3, 8'h02);            // clear coincides with the detected edge
    chk("R7 set wins over clear", ext_req[1], 1'b1);

    // R8: acknowledge clears the flag.
    ext_ack = 8'h02;
    @(negedge clk);
    ext_ack = 8'h00;
    chk("R8 ack clears", ext_req, 8'h00);

    // R11: latency of level and edge requests.
    ext_pin[3] = 1'b1;
    waitn(4);
    write_reg(3'd0, 8'h1A);
    write_reg(3'd2, 8'h03);            // pin 4 rising
    write_reg(3'd3, 8'hFF);
    ext_pin[3] = 1'b0;
    @(negedge clk);
    chk("R11 level after one edge", ext_req[3], 1'b0);
    @(negedge clk);
    chk("R11 level after two edges", ext_req[3], 1'b1);
    ext_pin[4] = 1'b1;
    @(negedge clk);
    chk("R11 flag after one edge", ext_req[4], 1'b0);
    @(negedge clk);
    chk("R11 flag after two edges", ext_req[4], 1'b0);
    @(negedge clk);
    chk("R11 flag after three edges", ext_req[4], 1'b1);

    // R9: pin-change banks.
    write_reg(3'd5, 8'h04);            // bank 1 watches pin 10
    write_reg(3'd6, 8'h80);            // bank 2 watches pin 23
    pc_pin[9] = 1'b1;
    pc_pin[2] = 1'b1;
    waitn(4);
    chk("R9 masked toggles ignored", pc_req, 3'b000);
    pc_pin[10] = 1'b1;
    waitn(4);
    chk("R9 bank1 toggle", pc_req, 3'b010);
    pc_pin[23] = 1'b1;
    waitn(4);
    chk("R9 bank2 toggle", pc_req, 3'b110);

    // R10: bank clearing.
    write_reg(3'd7, 8'h02);
    chk("R10 bank clear write", pc_req, 3'b100);
    pc_ack = 3'b100;
    @(negedge clk);
    pc_ack = 3'b000;
    chk("R10 bank ack", pc_req, 3'b000);
    pc_pin[10] = 1'b0;
    waitn(4);
    chk("R9 falling toggle", pc_req, 3'b010);
    global_en = 1'b0;
    @(negedge clk);
    chk("R6 bank gated", pc_req, 3'b000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule